// File: doc/BRIEF.md
# Rejected-Interrupt Replay Bitmap

This block keeps track of interrupts that the interrupt presenter has turned away, and replays them when asked. A reject input carries a global interrupt number. The block subtracts a configured base offset to get a local source number, and sets that source's bit in a two-level store. The store has 32 words of 64 bits each, plus a 32-bit summary register with one bit per word. A number that falls outside the local range raises a one-cycle error flag and is dropped.

A resend pulse starts a scan. The scan walks the summary from low to high words and skips every word whose summary bit is clear. It clears a word's summary bit before it enters that word. Inside the word it walks the bits from low to high, clears each set bit, and issues one forced retry request for that source toward the dispatch engine. Retries leave through a valid/ready handshake, and the scan waits while ready is low. A reject that arrives during a scan is still recorded. If it lands ahead of the scan position it is delivered in the current scan. If it lands behind that position it waits for the next resend.

Top module: `irq_reject_replay`

## Requirements
- R1: After reset `busy_o`, `retry_valid_o` and `rej_err_o` are low and the store is empty, so a following resend produces no retry.
- R2: A reject of global number g with offset o records local source s = g - o in word s>>6, bit s&63, and a later resend emits `retry_src_o` = s.
- R3: A reject with g < o or g - o >= 2048 raises `rej_err_o` for exactly the following cycle and records nothing; g - o = 2047 is accepted.
- R4: A resend while the summary is all zero produces no retry, and `busy_o` stays low.
- R5: A scan emits every recorded source exactly once, in strictly ascending order (word-major, then bit), with `retry_force_o` high on every request.
- R6: Each replayed source is cleared, so a second resend with no new rejects produces no retry.
- R7: While `retry_valid_o` is high and `retry_ready_i` is low, the request stays valid and `retry_src_o` does not change.
- R8: A reject recorded during a scan at a position ahead of the scan is delivered in that scan. One behind the scan position stays stored and is delivered by the next resend.
- R9: A resend pulse while `busy_o` is high is ignored: it neither restarts nor repeats the scan.
- R10: Repeated rejects of one source before a resend yield a single retry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_offset_i | input | 32 | Global number of local source 0 |
| rej_valid_i | input | 1 | Reject event strobe |
| rej_num_i | input | 32 | Global interrupt number that was rejected |
| rej_err_o | output | 1 | Previous-cycle reject was out of range |
| resend_i | input | 1 | Start a replay scan |
| busy_o | output | 1 | Scan in progress |
| retry_valid_o | output | 1 | Retry request valid |
| retry_ready_i | input | 1 | Dispatch engine accepts the request |
| retry_src_o | output | 11 | Local source number to retry |
| retry_force_o | output | 1 | Retry bypasses the pending/queued state |

## Verification
The hardest case to reach from the ports is a reject that lands while a scan is under way. Whether it is delivered depends on whether it falls before or after the scanner's current word and bit. The bench holds `retry_ready_i` low so the scan stalls on a known source. It then injects one reject into an already-passed bit of the same word and one into a later word. It checks that the second appears in the current scan and the first only after the next resend. Random rounds with clustered word choices and stalling ready patterns cover the summary skipping, and out-of-range numbers on both sides of the window cover the error path.

// File: rtl/irr_pkg.sv
package irr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FIND_W,
    ST_FIND_B,
    ST_SEND
  } scan_state_e;
endpackage

// File: rtl/irr_lsb_find.sv
module irr_lsb_find #(
  parameter int W  = 64,
  localparam int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  vec_i,
  output logic [IW-1:0] idx_o,
  output logic          found_o
);
  always_comb begin
    idx_o   = '0;
    found_o = 1'b0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec_i[i]) begin
        idx_o   = IW'(i);
        found_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/irr_rej_decode.sv
module irr_rej_decode #(
  parameter int GIRQ_W    = 32,
  parameter int NUM_WORDS = 32,
  parameter int WORD_BITS = 64,
  localparam int WI_W  = $clog2(NUM_WORDS),
  localparam int BI_W  = $clog2(WORD_BITS),
  localparam int SRC_W = WI_W + BI_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [GIRQ_W-1:0] cfg_offset_i,
  input  logic              rej_valid_i,
  input  logic [GIRQ_W-1:0] rej_num_i,
  output logic              set_en_o,
  output logic [WI_W-1:0]   set_word_o,
  output logic [BI_W-1:0]   set_bit_o,
  output logic              err_o
);
  logic [GIRQ_W-1:0] local_num;
  logic              no_borrow;
  logic              in_range;
  logic              err_q;

  assign local_num  = rej_num_i - cfg_offset_i;
  assign no_borrow  = rej_num_i >= cfg_offset_i;
  assign in_range   = no_borrow && (local_num[GIRQ_W-1:SRC_W] == '0);
  assign set_en_o   = rej_valid_i && in_range;
  assign set_word_o = local_num[SRC_W-1:BI_W];
  assign set_bit_o  = local_num[BI_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= rej_valid_i && !in_range;
  end

  assign err_o = err_q;
endmodule

// File: rtl/irr_bitmap.sv
module irr_bitmap #(
  parameter int NUM_WORDS = 32,
  parameter int WORD_BITS = 64,
  localparam int WI_W = $clog2(NUM_WORDS),
  localparam int BI_W = $clog2(WORD_BITS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 set_en_i,
  input  logic [WI_W-1:0]      set_word_i,
  input  logic [BI_W-1:0]      set_bit_i,
  input  logic                 clr_sum_en_i,
  input  logic [WI_W-1:0]      clr_sum_word_i,
  input  logic                 clr_bit_en_i,
  input  logic [BI_W-1:0]      clr_bit_i,
  input  logic [WI_W-1:0]      rd_word_i,
  output logic [NUM_WORDS-1:0] sum_o,
  output logic [WORD_BITS-1:0] rd_data_o
);
  logic [WORD_BITS-1:0] word_all [NUM_WORDS];

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    logic [WORD_BITS-1:0] word_q, word_d;
    logic                 sum_q, sum_d;
    logic                 set_hit;

    assign set_hit = set_en_i && (set_word_i == WI_W'(w));

    // a set in the same cycle as a clear wins: the new event is kept
    always_comb begin
      word_d = word_q;
      sum_d  = sum_q;
      if (clr_bit_en_i && rd_word_i == WI_W'(w)) word_d[clr_bit_i] = 1'b0;
      if (clr_sum_en_i && clr_sum_word_i == WI_W'(w)) sum_d = 1'b0;
      if (set_hit) begin
        word_d[set_bit_i] = 1'b1;
        sum_d             = 1'b1;
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        word_q <= '0;
        sum_q  <= 1'b0;
      end else begin
        word_q <= word_d;
        sum_q  <= sum_d;
      end
    end

    assign word_all[w] = word_q;
    assign sum_o[w]    = sum_q;
  end

  assign rd_data_o = word_all[rd_word_i];
endmodule

// File: rtl/irr_scanner.sv
module irr_scanner
  import irr_pkg::*;
#(
  parameter int NUM_WORDS = 32,
  parameter int WORD_BITS = 64,
  localparam int WI_W  = $clog2(NUM_WORDS),
  localparam int BI_W  = $clog2(WORD_BITS),
  localparam int SRC_W = WI_W + BI_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 resend_i,
  input  logic [NUM_WORDS-1:0] sum_i,
  input  logic [WORD_BITS-1:0] word_i,
  output logic [WI_W-1:0]      rd_word_o,
  output logic                 clr_sum_en_o,
  output logic [WI_W-1:0]      clr_sum_word_o,
  output logic                 clr_bit_en_o,
  output logic [BI_W-1:0]      clr_bit_o,
  output logic                 retry_valid_o,
  output logic [SRC_W-1:0]     retry_src_o,
  input  logic                 retry_ready_i,
  output logic                 busy_o
);
  localparam logic [BI_W-1:0] LAST_BIT = BI_W'(WORD_BITS - 1);

  scan_state_e       state_q, state_d;
  logic [WI_W:0]     wptr_q, wptr_d;
  logic [WI_W-1:0]   cur_q, cur_d;
  logic [BI_W:0]     bptr_q, bptr_d;
  logic [BI_W-1:0]   sel_q, sel_d;

  logic [NUM_WORDS-1:0] sum_masked;
  logic [WORD_BITS-1:0] word_masked;
  logic [WI_W-1:0]      w_idx;
  logic [BI_W-1:0]      b_idx;
  logic                 w_found, b_found;

  // only positions at or above the pointers are eligible
  assign sum_masked  = sum_i  & ({NUM_WORDS{1'b1}} << wptr_q);
  assign word_masked = word_i & ({WORD_BITS{1'b1}} << bptr_q);

  irr_lsb_find #(.W(NUM_WORDS)) u_find_w (
    .vec_i  (sum_masked),
    .idx_o  (w_idx),
    .found_o(w_found)
  );

  irr_lsb_find #(.W(WORD_BITS)) u_find_b (
    .vec_i  (word_masked),
    .idx_o  (b_idx),
    .found_o(b_found)
  );

  always_comb begin
    state_d        = state_q;
    wptr_d         = wptr_q;
    cur_d          = cur_q;
    bptr_d         = bptr_q;
    sel_d          = sel_q;
    clr_sum_en_o   = 1'b0;
    clr_sum_word_o = w_idx;
    clr_bit_en_o   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (resend_i && (|sum_i)) begin
          wptr_d  = '0;
          state_d = ST_FIND_W;
        end
      end
      ST_FIND_W: begin
        if (w_found) begin
          clr_sum_en_o = 1'b1;
          cur_d        = w_idx;
          bptr_d       = '0;
          state_d      = ST_FIND_B;
        end else begin
          state_d = ST_IDLE;
        end
      end
      ST_FIND_B: begin
        if (b_found) begin
          sel_d   = b_idx;
          state_d = ST_SEND;
        end else begin
          wptr_d  = {1'b0, cur_q} + (WI_W + 1)'(1);
          state_d = ST_FIND_W;
        end
      end
      ST_SEND: begin
        if (retry_ready_i) begin
          clr_bit_en_o = 1'b1;
          if (sel_q == LAST_BIT) begin
            wptr_d  = {1'b0, cur_q} + (WI_W + 1)'(1);
            state_d = ST_FIND_W;
          end else begin
            bptr_d  = {1'b0, sel_q} + (BI_W + 1)'(1);
            state_d = ST_FIND_B;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      wptr_q  <= '0;
      cur_q   <= '0;
      bptr_q  <= '0;
      sel_q   <= '0;
    end else begin
      state_q <= state_d;
      wptr_q  <= wptr_d;
      cur_q   <= cur_d;
      bptr_q  <= bptr_d;
      sel_q   <= sel_d;
    end
  end

  assign rd_word_o     = cur_q;
  assign clr_bit_o     = sel_q;
  assign retry_valid_o = (state_q == ST_SEND);
  assign retry_src_o   = {cur_q, sel_q};
  assign busy_o        = (state_q != ST_IDLE);
endmodule

// File: rtl/irq_reject_replay.sv
module irq_reject_replay #(
  parameter int GIRQ_W    = 32,
  parameter int NUM_WORDS = 32,
  parameter int WORD_BITS = 64,
  localparam int WI_W  = $clog2(NUM_WORDS),
  localparam int BI_W  = $clog2(WORD_BITS),
  localparam int SRC_W = WI_W + BI_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [GIRQ_W-1:0] cfg_offset_i,
  input  logic              rej_valid_i,
  input  logic [GIRQ_W-1:0] rej_num_i,
  output logic              rej_err_o,
  input  logic              resend_i,
  output logic              busy_o,
  output logic              retry_valid_o,
  input  logic              retry_ready_i,
  output logic [SRC_W-1:0]  retry_src_o,
  output logic              retry_force_o
);
  logic                 set_en;
  logic [WI_W-1:0]      set_word;
  logic [BI_W-1:0]      set_bit;
  logic                 clr_sum_en, clr_bit_en;
  logic [WI_W-1:0]      clr_sum_word, rd_word;
  logic [BI_W-1:0]      clr_bit;
  logic [NUM_WORDS-1:0] sum;
  logic [WORD_BITS-1:0] rd_data;

  irr_rej_decode #(
    .GIRQ_W(GIRQ_W), .NUM_WORDS(NUM_WORDS), .WORD_BITS(WORD_BITS)
  ) u_decode (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cfg_offset_i(cfg_offset_i),
    .rej_valid_i (rej_valid_i),
    .rej_num_i   (rej_num_i),
    .set_en_o    (set_en),
    .set_word_o  (set_word),
    .set_bit_o   (set_bit),
    .err_o       (rej_err_o)
  );

  irr_bitmap #(.NUM_WORDS(NUM_WORDS), .WORD_BITS(WORD_BITS)) u_bitmap (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .set_en_i      (set_en),
    .set_word_i    (set_word),
    .set_bit_i     (set_bit),
    .clr_sum_en_i  (clr_sum_en),
    .clr_sum_word_i(clr_sum_word),
    .clr_bit_en_i  (clr_bit_en),
    .clr_bit_i     (clr_bit),
    .rd_word_i     (rd_word),
    .sum_o         (sum),
    .rd_data_o     (rd_data)
  );

  irr_scanner #(.NUM_WORDS(NUM_WORDS), .WORD_BITS(WORD_BITS)) u_scan (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .resend_i      (resend_i),
    .sum_i         (sum),
    .word_i        (rd_data),
    .rd_word_o     (rd_word),
    .clr_sum_en_o  (clr_sum_en),
    .clr_sum_word_o(clr_sum_word),
    .clr_bit_en_o  (clr_bit_en),
    .clr_bit_o     (clr_bit),
    .retry_valid_o (retry_valid_o),
    .retry_src_o   (retry_src_o),
    .retry_ready_i (retry_ready_i),
    .busy_o        (busy_o)
  );

  // every replay bypasses the pending/queued state downstream
  assign retry_force_o = retry_valid_o;
endmodule

// File: rtl/irr_checker.sv
module irr_checker #(
  parameter int SRC_W = 11
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             rej_valid_i,
  input logic             rej_err_i,
  input logic             busy_i,
  input logic             retry_valid_i,
  input logic             retry_ready_i,
  input logic [SRC_W-1:0] retry_src_i
);
  logic             have_last;
  logic [SRC_W-1:0] last_src;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      have_last <= 1'b0;
      last_src  <= '0;
    end else if (!busy_i) begin
      have_last <= 1'b0;
    end else if (retry_valid_i && retry_ready_i) begin
      have_last <= 1'b1;
      last_src  <= retry_src_i;
    end
  end

  AST_RETRY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retry_valid_i && !retry_ready_i |=> retry_valid_i && $stable(retry_src_i)); // R7

  AST_ERR_FROM_REJ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rej_err_i |-> $past(rej_valid_i)); // R3

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> !retry_valid_i); // R1

  AST_ASCENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retry_valid_i && retry_ready_i && have_last |-> retry_src_i > last_src); // R5
endmodule

bind irq_reject_replay irr_checker #(.SRC_W(SRC_W)) u_irr_checker (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .rej_valid_i  (rej_valid_i),
  .rej_err_i    (rej_err_o),
  .busy_i       (busy_o),
  .retry_valid_i(retry_valid_o),
  .retry_ready_i(retry_ready_i),
  .retry_src_i  (retry_src_o)
);

// File: tb/tb_irq_reject_replay.sv
module tb_irq_reject_replay;
  localparam int CLK_PERIOD = 10;
  localparam int TOTAL      = 2048;
  localparam int WATCHDOG   = 150000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] cfg_offset_i = '0;
  logic        rej_valid_i = 1'b0;
  logic [31:0] rej_num_i = '0;
  logic        rej_err_o;
  logic        resend_i = 1'b0;
  logic        busy_o;
  logic        retry_valid_o;
  logic        retry_ready_i = 1'b0;
  logic [10:0] retry_src_o;
  logic        retry_force_o;

  int errors = 0;
  int checks = 0;
  int rdy_mode = 0;   // 0 random, 1 held low, 2 held high
  int got_q[$];
  bit model [TOTAL];

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  irq_reject_replay dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .cfg_offset_i(cfg_offset_i),
    .rej_valid_i(rej_valid_i), .rej_num_i(rej_num_i), .rej_err_o(rej_err_o),
    .resend_i(resend_i), .busy_o(busy_o), .retry_valid_o(retry_valid_o),
    .retry_ready_i(retry_ready_i), .retry_src_o(retry_src_o),
    .retry_force_o(retry_force_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit exp_err(input int unsigned g, input int unsigned o);
    return (g < o) || (g - o >= TOTAL);
  endfunction

  // handshake monitor, owns retry_ready_i
  initial begin
    bit pv = 0, pr = 0;
    int psrc = 0;
    forever begin
      @(negedge clk_i);
      if (rst_ni) begin
        if (pv && !pr)
          check(retry_valid_o && int'(retry_src_o) == psrc, "R7 stall hold",
                int'(retry_src_o), psrc);
        case (rdy_mode)
          0:       retry_ready_i = ($urandom_range(0, 2) != 0);
          1:       retry_ready_i = 1'b0;
          default: retry_ready_i = 1'b1;
        endcase
        if (retry_valid_o && retry_ready_i) begin
          got_q.push_back(int'(retry_src_o));
          check(retry_force_o, "R5 force", int'(retry_force_o), 1);
        end
        pv = retry_valid_o; pr = retry_ready_i; psrc = int'(retry_src_o);
      end
    end
  end

  task automatic do_rej(input int unsigned g);
    bit e;
    e = exp_err(g, cfg_offset_i);
    rej_valid_i = 1'b1;
    rej_num_i   = g;
    @(negedge clk_i);
    rej_valid_i = 1'b0;
    check(rej_err_o == e, "R3 err flag", int'(rej_err_o), int'(e));
    if (!e) model[g - cfg_offset_i] = 1'b1;
  endtask

  task automatic pulse_resend();
    resend_i = 1'b1;
    @(negedge clk_i);
    resend_i = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 20000 && busy_o; i++) @(negedge clk_i);
    @(negedge clk_i);
  endtask

  // compare collected retries against the model, ascending, then clear model
  task automatic compare_round(input string req);
    int exp_q[$];
    bit ok;
    for (int s = 0; s < TOTAL; s++) if (model[s]) exp_q.push_back(s);
    ok = (exp_q.size() == got_q.size());
    for (int i = 0; ok && i < exp_q.size(); i++) ok = (exp_q[i] == got_q[i]);
    check(ok, req, got_q.size(), exp_q.size());
    for (int s = 0; s < TOTAL; s++) model[s] = 1'b0;
    got_q.delete();
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(!busy_o && !retry_valid_o && !rej_err_o, "R1 reset state",
          int'({busy_o, retry_valid_o, rej_err_o}), 0);

    // R4: empty store
    pulse_resend();
    check(!busy_o, "R4 busy after empty resend", int'(busy_o), 0);
    repeat (5) @(negedge clk_i);
    check(got_q.size() == 0, "R1 R4 no retry when empty", got_q.size(), 0);

    // R2 R3 boundaries with offset
    cfg_offset_i = 32'd100;
    do_rej(32'd99);
    do_rej(32'd100 + 2048);
    do_rej(32'd100 + 2047);
    do_rej(32'd100);
    // R10 duplicates
    do_rej(32'd100 + 70);
    do_rej(32'd100 + 70);
    do_rej(32'd100 + 70);
    pulse_resend();
    wait_idle();
    check(got_q.size() == 3, "R10 dup count", got_q.size(), 3);
    compare_round("R2 R5 boundary order");

    // R6: second resend empty
    pulse_resend();
    wait_idle();
    check(got_q.size() == 0, "R6 cleared after replay", got_q.size(), 0);

    // R8 R9 directed mid-scan rejects
    do_rej(32'd100 + 5);
    do_rej(32'd100 + 193);
    rdy_mode = 1;
    pulse_resend();
    for (int i = 0; i < 50 && !retry_valid_o; i++) @(negedge clk_i);
    check(retry_valid_o && retry_src_o == 11'd5, "R8 first held src",
          int'(retry_src_o), 5);
    do_rej(32'd100 + 2);      // behind scan position
    do_rej(32'd100 + 647);    // word 10 bit 7, ahead
    pulse_resend();           // busy: ignored
    rdy_mode = 0;
    wait_idle();
    begin
      bit ok;
      ok = (got_q.size() == 3) && got_q[0] == 5 && got_q[1] == 193 && got_q[2] == 647;
      check(ok, "R8 R9 mid-scan delivery", got_q.size(), 3);
    end
    got_q.delete();
    pulse_resend();
    wait_idle();
    check(got_q.size() == 1 && got_q[0] == 2, "R8 passed bit kept",
          got_q.size() > 0 ? got_q[0] : -1, 2);
    got_q.delete();
    for (int s = 0; s < TOTAL; s++) model[s] = 1'b0;

    // random rounds with clustered words
    for (int r = 0; r < 12; r++) begin
      int unsigned wsel [4];
      cfg_offset_i = $urandom_range(0, 5000);
      for (int k = 0; k < 4; k++) wsel[k] = $urandom_range(0, 31);
      rdy_mode = (r % 3 == 2) ? 2 : 0;
      for (int n = 0; n < 30; n++) begin
        int unsigned pick;
        int unsigned g;
        pick = $urandom_range(0, 9);
        if (pick == 0)
          g = cfg_offset_i + 2048 + $urandom_range(0, 300);
        else if (pick == 1 && cfg_offset_i > 0)
          g = $urandom_range(0, cfg_offset_i - 1);
        else
          g = cfg_offset_i + wsel[$urandom_range(0, 3)] * 64 + $urandom_range(0, 63);
        do_rej(g);
      end
      pulse_resend();
      wait_idle();
      compare_round("R2 R5 R10 random round");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk_i);
    errors++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule